// File: doc/BRIEF.md
# Dual Host-Port Transmit/Receive Register Bank

This block is the processor-facing register bank of a host port, with two identical copies. Each copy has four word addresses. It holds a control word, a read-only status word, a receive word that the host fills, and a transmit word that the processor writes and the host picks up. The transmit word can be written at two addresses. The plain address only loads the data. The clearing address also drops the pending flags for program, X and Y memory reads.

A one-deep internal path moves a waiting transmit word into the host-side receive register. A per-port state machine drives this path. Its states are `TX_EMPTY` (nothing waiting, host register empty), `TX_LOADED` (a word is waiting and the host register is free), `TX_DELIV` (nothing waiting, the host holds a word) and `TX_STALL` (a word is waiting and the host still holds the previous one). The transitions are as follows:
- A processor transmit write takes `TX_EMPTY` to `TX_LOADED`.
- The transfer takes `TX_LOADED` to `TX_DELIV`, or to `TX_STALL` if a new write arrives in the same cycle.
- A host read takes `TX_DELIV` to `TX_EMPTY`, or to `TX_LOADED` if it comes with a write.
- A write takes `TX_DELIV` to `TX_STALL`.
- A host read takes `TX_STALL` to `TX_LOADED`.

The receive side is a two-state machine:
- A host write takes `RX_VACANT` to `RX_HELD`.
- A processor read of the data word takes `RX_HELD` back to `RX_VACANT`.

Interrupt requests come from the status flags ANDed with enable bits in the control word. The host side is modelled as plain strobes: a read strobe, a write strobe with data, pulses that set pending memory flags, a command level and two input flags.

Top module: `hpx_bank`

## Requirements
- R1: After reset, in every port, the status word reads 0x0000_0002 (transmit-empty set, everything else clear). The control word is zero, `host_rxfull` and `host_mreq` are low, and all interrupt outputs are low.
- R2: Port addresses decode as follows. On reads, address 0 returns control, address 1 returns status, address 2 returns zero and address 3 returns the receive word. On writes, address 0 loads control, address 1 does nothing, address 2 is the clearing transmit address and address 3 is the plain transmit address.
- R3: Only control bits 4:0 and 14:9 are storable; a write of all ones reads back 0x0000_7E1F. A write to address 1 changes no visible state.
- R4: A plain transmit write clears transmit-empty (status bit 1) on the next clock and leaves the pending flags unchanged.
- R5: A clearing transmit write clears transmit-empty and the read-pending flags (status bits 9, 11, 13). It leaves the write-pending flags (bits 10, 12, 14) unchanged.
- R6: When transmit-empty and `host_rxfull` are both low at a clock edge, that edge copies the transmit word to `host_rdata`, sets `host_rxfull` and transmit-empty, and clears `host_mreq` (a same-edge request pulse wins). `host_rdata` changes at no other time.
- R7: While `host_rxfull` is high, waiting data is not transferred. A `host_rd` pulse clears `host_rxfull` at the next edge, and the waiting word moves over at the edge after.
- R8: `irq_tx` = transmit-empty AND control bit 1; `irq_rx` = receive-full (status bit 0) AND control bit 0; `irq_cmd` = command-pending (status bit 2) AND control bit 2.
- R9: A `host_wr` pulse loads the receive word and sets status bit 0. A processor read (`cpu_rd`) of address 3 clears status bit 0 and the write-pending flags at the next edge. A same-edge host event wins.
- R10: Bit i of a port's `host_req` slice sets status bit 9+i (0 P-read, 1 P-write, 2 X-read, 3 X-write, 4 Y-read, 5 Y-write) and sets `host_mreq`. `irq_mem` is high when any pending flag has its enable at the same control bit position.
- R11: Status bits 3 and 4 show `host_flag_in` and status bit 2 shows `host_cmd`, each one clock late. Control bits 3 and 4 drive `host_flag_out`.
- R12: The ports are independent; an access selecting one port never changes the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_sel | input | SEL_W | Port selected by the processor access |
| cpu_addr | input | 2 | Word address within the port |
| cpu_wr | input | 1 | Processor write strobe |
| cpu_rd | input | 1 | Processor read strobe (side effects on address 3) |
| cpu_wdata | input | DATA_W | Processor write data |
| cpu_rdata | output | DATA_W | Processor read data, combinational |
| host_wr | input | NPORTS | Host write strobe per port |
| host_wdata | input | NPORTS*DATA_W | Host write data per port |
| host_rd | input | NPORTS | Host read strobe per port |
| host_rdata | output | NPORTS*DATA_W | Host-side receive register per port |
| host_rxfull | output | NPORTS | Host-side receive register full |
| host_req | input | NPORTS*6 | Pending memory request set pulses |
| host_cmd | input | NPORTS | Host command level |
| host_flag_in | input | NPORTS*2 | Flags from host |
| host_flag_out | output | NPORTS*2 | Flags to host |
| host_mreq | output | NPORTS | Memory request outstanding |
| irq_rx | output | NPORTS | Receive interrupt request |
| irq_tx | output | NPORTS | Transmit interrupt request |
| irq_cmd | output | NPORTS | Command interrupt request |
| irq_mem | output | NPORTS | Memory pending interrupt request |

## Verification
Every flag, the control word and the interrupt outputs change one clock after the strobe that causes them. A transmit write reaches `host_rdata` two edges after it is driven: one edge to load the word and one to transfer it. After a `host_rd` that unblocks a stalled word, `host_rxfull` drops for exactly one cycle before the word lands. Read data is combinational over registered state, so it reflects the last edge. The bench drives inputs on the falling edge and compares every output against its behavioural model one nanosecond later. Directed checks wait the exact number of falling edges that these latencies give.

// File: rtl/hpx_pkg.sv
`timescale 1ns/1ps
package hpx_pkg;

    localparam int PEND_N  = 6;
    localparam int PEND_LO = 9;

    // status bit positions
    localparam int B_RDF = 0;
    localparam int B_TDE = 1;
    localparam int B_CMD = 2;
    localparam int B_HFI = 3;   // two bits, 4:3

    // control bit positions
    localparam int C_RIE = 0;
    localparam int C_TIE = 1;
    localparam int C_CIE = 2;
    localparam int C_HFO = 3;   // two bits, 4:3

    // pending order: P-read, P-write, X-read, X-write, Y-read, Y-write
    localparam logic [PEND_N-1:0] RD_PEND = 6'b010101;
    localparam logic [PEND_N-1:0] WR_PEND = 6'b101010;

    typedef enum logic [1:0] {
        A_CTRL = 2'd0,
        A_STAT = 2'd1,
        A_TXC  = 2'd2,
        A_DATA = 2'd3
    } addr_e;

    typedef enum logic [1:0] {
        TX_EMPTY  = 2'd0,
        TX_LOADED = 2'd1,
        TX_DELIV  = 2'd2,
        TX_STALL  = 2'd3
    } tx_state_e;

    typedef enum logic {
        RX_VACANT = 1'b0,
        RX_HELD   = 1'b1
    } rx_state_e;

endpackage

// File: rtl/hpx_txpath.sv
`timescale 1ns/1ps
module hpx_txpath
    import hpx_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_load,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              host_rd,
    output logic              tx_empty,
    output logic              rx_full,
    output logic              xfer,
    output logic [DATA_W-1:0] host_rx
);

    tx_state_e         st_q, st_d;
    logic [DATA_W-1:0] hold_q;
    logic [DATA_W-1:0] hrx_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= TX_EMPTY;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            TX_EMPTY:  st_d = tx_load ? TX_LOADED : TX_EMPTY;
            TX_LOADED: st_d = tx_load ? TX_STALL  : TX_DELIV;
            TX_DELIV: begin
                if (tx_load) st_d = host_rd ? TX_LOADED : TX_STALL;
                else         st_d = host_rd ? TX_EMPTY  : TX_DELIV;
            end
            TX_STALL:  st_d = host_rd ? TX_LOADED : TX_STALL;
            default:   st_d = TX_EMPTY;
        endcase
    end

    always_comb begin
        tx_empty = 1'b0;
        rx_full  = 1'b0;
        xfer     = 1'b0;
        unique case (st_q)
            TX_EMPTY:  tx_empty = 1'b1;
            TX_LOADED: xfer     = 1'b1;
            TX_DELIV: begin
                tx_empty = 1'b1;
                rx_full  = 1'b1;
            end
            TX_STALL:  rx_full  = 1'b1;
            default:   tx_empty = 1'b1;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_q <= '0;
            hrx_q  <= '0;
        end else begin
            if (xfer)    hrx_q  <= hold_q;
            if (tx_load) hold_q <= tx_data;
        end
    end

    assign host_rx = hrx_q;

endmodule

// File: rtl/hpx_ctl.sv
`timescale 1ns/1ps
module hpx_ctl
    import hpx_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_wr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              txc_wr,
    input  logic              rx_rd,
    input  logic              host_wr,
    input  logic [DATA_W-1:0] host_wdata,
    input  logic [PEND_N-1:0] host_req,
    input  logic              host_cmd,
    input  logic [1:0]        host_flag_in,
    input  logic              xfer,
    output logic [DATA_W-1:0] ctrl_q,
    output logic [PEND_N-1:0] pend_q,
    output logic              rdf,
    output logic              cmd_q,
    output logic [1:0]        hfi_q,
    output logic [DATA_W-1:0] rx_q,
    output logic              mreq_q
);

    localparam logic [DATA_W-1:0] LOW_MASK  = DATA_W'((1 << (C_HFO + 2)) - 1);
    localparam logic [DATA_W-1:0] PEND_MASK = DATA_W'(((1 << PEND_N) - 1) << PEND_LO);
    localparam logic [DATA_W-1:0] CTRL_MASK = LOW_MASK | PEND_MASK;

    rx_state_e         rx_st_q, rx_st_d;
    logic [PEND_N-1:0] pend_d;

    // receive-side state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rx_st_q <= RX_VACANT;
        else        rx_st_q <= rx_st_d;
    end

    always_comb begin
        rx_st_d = rx_st_q;
        unique case (rx_st_q)
            RX_VACANT: rx_st_d = host_wr ? RX_HELD : RX_VACANT;
            RX_HELD:   rx_st_d = (rx_rd && !host_wr) ? RX_VACANT : RX_HELD;
            default:   rx_st_d = RX_VACANT;
        endcase
    end

    assign rdf = (rx_st_q == RX_HELD);

    // pending flags: clears first, set pulses win
    always_comb begin
        pend_d = pend_q;
        if (txc_wr) pend_d = pend_d & ~RD_PEND;
        if (rx_rd)  pend_d = pend_d & ~WR_PEND;
        pend_d = pend_d | host_req;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            pend_q <= '0;
            cmd_q  <= 1'b0;
            hfi_q  <= '0;
            rx_q   <= '0;
            mreq_q <= 1'b0;
        end else begin
            if (ctrl_wr) ctrl_q <= wdata & CTRL_MASK;
            pend_q <= pend_d;
            cmd_q  <= host_cmd;
            hfi_q  <= host_flag_in;
            if (host_wr) rx_q <= host_wdata;
            if (|host_req)  mreq_q <= 1'b1;
            else if (xfer)  mreq_q <= 1'b0;
        end
    end

endmodule

// File: rtl/hpx_port.sv
`timescale 1ns/1ps
module hpx_port
    import hpx_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_wr,
    input  logic              cpu_rd,
    input  logic [1:0]        cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic [DATA_W-1:0] cpu_rdata,
    input  logic              host_wr,
    input  logic [DATA_W-1:0] host_wdata,
    input  logic              host_rd,
    output logic [DATA_W-1:0] host_rdata,
    output logic              host_rxfull,
    input  logic [PEND_N-1:0] host_req,
    input  logic              host_cmd,
    input  logic [1:0]        host_flag_in,
    output logic [1:0]        host_flag_out,
    output logic              host_mreq,
    output logic              irq_rx,
    output logic              irq_tx,
    output logic              irq_cmd,
    output logic              irq_mem
);

    addr_e             adr;
    logic              ctrl_wr, txc_wr, txp_wr, rx_rd;
    logic              tx_empty, xfer;
    logic [DATA_W-1:0] ctrl_q, rx_q, status;
    logic [PEND_N-1:0] pend_q;
    logic              rdf, cmd_q, mreq_q;
    logic [1:0]        hfi_q;

    assign adr     = addr_e'(cpu_addr);
    assign ctrl_wr = cpu_wr && (adr == A_CTRL);
    assign txc_wr  = cpu_wr && (adr == A_TXC);
    assign txp_wr  = cpu_wr && (adr == A_DATA);
    assign rx_rd   = cpu_rd && (adr == A_DATA);

    hpx_txpath #(.DATA_W(DATA_W)) u_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .tx_load  (txc_wr | txp_wr),
        .tx_data  (cpu_wdata),
        .host_rd  (host_rd),
        .tx_empty (tx_empty),
        .rx_full  (host_rxfull),
        .xfer     (xfer),
        .host_rx  (host_rdata)
    );

    hpx_ctl #(.DATA_W(DATA_W)) u_ctl (
        .clk          (clk),
        .rst_n        (rst_n),
        .ctrl_wr      (ctrl_wr),
        .wdata        (cpu_wdata),
        .txc_wr       (txc_wr),
        .rx_rd        (rx_rd),
        .host_wr      (host_wr),
        .host_wdata   (host_wdata),
        .host_req     (host_req),
        .host_cmd     (host_cmd),
        .host_flag_in (host_flag_in),
        .xfer         (xfer),
        .ctrl_q       (ctrl_q),
        .pend_q       (pend_q),
        .rdf          (rdf),
        .cmd_q        (cmd_q),
        .hfi_q        (hfi_q),
        .rx_q         (rx_q),
        .mreq_q       (mreq_q)
    );

    always_comb begin
        status = '0;
        status[B_RDF]                    = rdf;
        status[B_TDE]                    = tx_empty;
        status[B_CMD]                    = cmd_q;
        status[B_HFI +: 2]               = hfi_q;
        status[PEND_LO +: PEND_N]        = pend_q;
    end

    always_comb begin
        cpu_rdata = '0;
        unique case (adr)
            A_CTRL: cpu_rdata = ctrl_q;
            A_STAT: cpu_rdata = status;
            A_TXC:  cpu_rdata = '0;
            A_DATA: cpu_rdata = rx_q;
            default: cpu_rdata = '0;
        endcase
    end

    assign host_flag_out = ctrl_q[C_HFO +: 2];
    assign host_mreq     = mreq_q;
    assign irq_rx        = rdf      & ctrl_q[C_RIE];
    assign irq_tx        = tx_empty & ctrl_q[C_TIE];
    assign irq_cmd       = cmd_q    & ctrl_q[C_CIE];
    assign irq_mem       = |(pend_q & ctrl_q[PEND_LO +: PEND_N]);

endmodule

// File: rtl/hpx_bank.sv
`timescale 1ns/1ps
module hpx_bank
    import hpx_pkg::*;
#(
    parameter int NPORTS = 2,
    parameter int DATA_W = 32,
    localparam int SEL_W = (NPORTS > 1) ? $clog2(NPORTS) : 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [SEL_W-1:0]         cpu_sel,
    input  logic [1:0]               cpu_addr,
    input  logic                     cpu_wr,
    input  logic                     cpu_rd,
    input  logic [DATA_W-1:0]        cpu_wdata,
    output logic [DATA_W-1:0]        cpu_rdata,
    input  logic [NPORTS-1:0]        host_wr,
    input  logic [NPORTS*DATA_W-1:0] host_wdata,
    input  logic [NPORTS-1:0]        host_rd,
    output logic [NPORTS*DATA_W-1:0] host_rdata,
    output logic [NPORTS-1:0]        host_rxfull,
    input  logic [NPORTS*PEND_N-1:0] host_req,
    input  logic [NPORTS-1:0]        host_cmd,
    input  logic [NPORTS*2-1:0]      host_flag_in,
    output logic [NPORTS*2-1:0]      host_flag_out,
    output logic [NPORTS-1:0]        host_mreq,
    output logic [NPORTS-1:0]        irq_rx,
    output logic [NPORTS-1:0]        irq_tx,
    output logic [NPORTS-1:0]        irq_cmd,
    output logic [NPORTS-1:0]        irq_mem
);

    logic [DATA_W-1:0] port_rdata [NPORTS];

    for (genvar p = 0; p < NPORTS; p++) begin : g_port
        logic hit;
        assign hit = (cpu_sel == SEL_W'(p));

        hpx_port #(.DATA_W(DATA_W)) u_port (
            .clk           (clk),
            .rst_n         (rst_n),
            .cpu_wr        (cpu_wr && hit),
            .cpu_rd        (cpu_rd && hit),
            .cpu_addr      (cpu_addr),
            .cpu_wdata     (cpu_wdata),
            .cpu_rdata     (port_rdata[p]),
            .host_wr       (host_wr[p]),
            .host_wdata    (host_wdata[p*DATA_W +: DATA_W]),
            .host_rd       (host_rd[p]),
            .host_rdata    (host_rdata[p*DATA_W +: DATA_W]),
            .host_rxfull   (host_rxfull[p]),
            .host_req      (host_req[p*PEND_N +: PEND_N]),
            .host_cmd      (host_cmd[p]),
            .host_flag_in  (host_flag_in[p*2 +: 2]),
            .host_flag_out (host_flag_out[p*2 +: 2]),
            .host_mreq     (host_mreq[p]),
            .irq_rx        (irq_rx[p]),
            .irq_tx        (irq_tx[p]),
            .irq_cmd       (irq_cmd[p]),
            .irq_mem       (irq_mem[p])
        );
    end

    always_comb begin
        cpu_rdata = '0;
        for (int i = 0; i < NPORTS; i++) begin
            if (cpu_sel == SEL_W'(i)) cpu_rdata = port_rdata[i];
        end
    end

endmodule

// File: rtl/hpx_bank_chk.sv
`timescale 1ns/1ps
module hpx_bank_chk #(
    parameter int NPORTS = 2,
    parameter int DATA_W = 32,
    localparam int SEL_W = (NPORTS > 1) ? $clog2(NPORTS) : 1
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic [SEL_W-1:0]         cpu_sel,
    input logic [1:0]               cpu_addr,
    input logic                     cpu_wr,
    input logic [NPORTS-1:0]        host_rd,
    input logic [NPORTS*6-1:0]      host_req,
    input logic [NPORTS*DATA_W-1:0] host_rdata,
    input logic [NPORTS-1:0]        host_rxfull,
    input logic [NPORTS-1:0]        host_mreq,
    input logic [NPORTS*2-1:0]      host_flag_out
);

    for (genvar i = 0; i < NPORTS; i++) begin : g_chk

        p_leave_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(rst_n) |-> (!host_rxfull[i] && !host_mreq[i]));

        p_rdata_only_on_fill_r6: assert property (@(posedge clk) disable iff (!rst_n)
            !$rose(host_rxfull[i]) |-> $stable(host_rdata[i*DATA_W +: DATA_W]));

        p_fill_clears_mreq_r6: assert property (@(posedge clk) disable iff (!rst_n)
            ($rose(host_rxfull[i]) && !$past(|host_req[i*6 +: 6])) |-> !host_mreq[i]);

        p_host_read_empties_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (host_rd[i] && host_rxfull[i]) |=> !host_rxfull[i]);

        p_full_held_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (host_rxfull[i] && !host_rd[i]) |=> host_rxfull[i]);

        p_flag_out_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
            !(cpu_wr && cpu_addr == 2'd0 && cpu_sel == SEL_W'(i))
                |=> $stable(host_flag_out[i*2 +: 2]));
    end

endmodule

bind hpx_bank hpx_bank_chk #(.NPORTS(NPORTS), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/hpx_bank_test.sv
`timescale 1ns/1ps
module hpx_bank_test;

    localparam int NP = 2;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [0:0]    cpu_sel = '0;
    logic [1:0]    cpu_addr = '0;
    logic          cpu_wr = 1'b0, cpu_rd = 1'b0;
    logic [DW-1:0] cpu_wdata = '0;
    logic [DW-1:0] cpu_rdata;
    logic [NP-1:0] host_wr = '0, host_rd = '0, host_cmd = '0;
    logic [NP*DW-1:0] host_wdata = '0, host_rdata;
    logic [NP-1:0] host_rxfull, host_mreq, irq_rx, irq_tx, irq_cmd, irq_mem;
    logic [NP*6-1:0] host_req = '0;
    logic [NP*2-1:0] host_flag_in = '0, host_flag_out;

    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    hpx_bank #(.NPORTS(NP), .DATA_W(DW)) uut (.*);

    // behavioural reference model
    bit          m_te [NP], m_rf [NP], m_rdf [NP], m_mreq [NP], m_cmd [NP];
    logic [1:0]  m_hf [NP];
    logic [5:0]  m_pend [NP];
    logic [31:0] m_ctrl [NP], m_tx [NP], m_hrx [NP], m_rx [NP];

    function automatic logic [31:0] m_status(int p);
        return (32'(m_pend[p]) << 9) | (32'(m_hf[p]) << 3) |
               (32'(m_cmd[p]) << 2) | (32'(m_te[p]) << 1) | 32'(m_rdf[p]);
    endfunction

    function automatic logic [31:0] m_read(int p, int a);
        case (a)
            0: return m_ctrl[p];
            1: return m_status(p);
            3: return m_rx[p];
            default: return 32'h0;
        endcase
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int p = 0; p < NP; p++) begin
                m_te[p] = 1; m_rf[p] = 0; m_rdf[p] = 0; m_mreq[p] = 0; m_cmd[p] = 0;
                m_hf[p] = 0; m_pend[p] = 0; m_ctrl[p] = 0; m_tx[p] = 0;
                m_hrx[p] = 0; m_rx[p] = 0;
            end
        end else begin
            for (int p = 0; p < NP; p++) begin
                bit wr, rd, go;
                logic [5:0] rq;
                wr = cpu_wr && (int'(cpu_sel) == p);
                rd = cpu_rd && (int'(cpu_sel) == p);
                rq = host_req[p*6 +: 6];
                go = !m_te[p] && !m_rf[p];
                if (go) begin
                    m_hrx[p] = m_tx[p]; m_rf[p] = 1; m_te[p] = 1; m_mreq[p] = 0;
                end else if (host_rd[p] && m_rf[p]) m_rf[p] = 0;
                if (wr && cpu_addr == 2'd0) m_ctrl[p] = cpu_wdata & 32'h7E1F;
                if (wr && cpu_addr >= 2'd2) begin
                    m_tx[p] = cpu_wdata; m_te[p] = 0;
                    if (cpu_addr == 2'd2) m_pend[p] = m_pend[p] & 6'b101010;
                end
                if (rd && cpu_addr == 2'd3) begin
                    m_rdf[p] = 0; m_pend[p] = m_pend[p] & 6'b010101;
                end
                if (host_wr[p]) begin
                    m_rx[p] = host_wdata[p*DW +: DW]; m_rdf[p] = 1;
                end
                m_pend[p] = m_pend[p] | rq;
                if (|rq) m_mreq[p] = 1;
                m_cmd[p] = host_cmd[p];
                m_hf[p] = host_flag_in[p*2 +: 2];
            end
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // cycle-by-cycle comparison, away from the rising edge
    always @(negedge clk) begin
        #1;
        if (rst_n && !done) begin
            for (int p = 0; p < NP; p++) begin
                check("R6 host_rxfull", 32'(host_rxfull[p]), 32'(m_rf[p]));
                check("R6 host_rdata", host_rdata[p*DW +: DW], m_hrx[p]);
                check("R6 host_mreq", 32'(host_mreq[p]), 32'(m_mreq[p]));
                check("R8 irq_tx", 32'(irq_tx[p]), 32'(m_te[p] & m_ctrl[p][1]));
                check("R8 irq_rx", 32'(irq_rx[p]), 32'(m_rdf[p] & m_ctrl[p][0]));
                check("R8 irq_cmd", 32'(irq_cmd[p]), 32'(m_cmd[p] & m_ctrl[p][2]));
                check("R10 irq_mem", 32'(irq_mem[p]), 32'(|(m_pend[p] & m_ctrl[p][14:9])));
                check("R11 host_flag_out", 32'(host_flag_out[p*2 +: 2]), 32'(m_ctrl[p][4:3]));
            end
            check("R2 cpu_rdata", cpu_rdata, m_read(int'(cpu_sel), int'(cpu_addr)));
        end
    end

    task automatic cpu_write(input int s, input int a, input logic [31:0] d);
        @(negedge clk);
        cpu_sel = 1'(s); cpu_addr = 2'(a); cpu_wdata = d; cpu_wr = 1'b1;
        @(negedge clk);
        cpu_wr = 1'b0; cpu_addr = 2'd1;
    endtask

    task automatic cpu_read(input int s, input int a);
        @(negedge clk);
        cpu_sel = 1'(s); cpu_addr = 2'(a); cpu_rd = 1'b1;
        @(negedge clk);
        cpu_rd = 1'b0;
    endtask

    task automatic rd_expect(input int s, input int a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        cpu_sel = 1'(s); cpu_addr = 2'(a);
        #1;
        check(tag, cpu_rdata, exp);
    endtask

    task automatic pulse_req(input int p, input logic [5:0] v);
        @(negedge clk);
        host_req[p*6 +: 6] = v;
        @(negedge clk);
        host_req = '0;
    endtask

    task automatic pulse_hrd(input int p);
        @(negedge clk);
        host_rd[p] = 1'b1;
        @(negedge clk);
        host_rd[p] = 1'b0;
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        // R1 during reset
        #1;
        check("R1 rxfull in reset", 32'(host_rxfull), 32'h0);
        check("R1 irq in reset", 32'({irq_rx, irq_tx, irq_cmd, irq_mem}), 32'h0);
        rst_n = 1'b1;
        rd_expect(0, 1, 32'h2, "R1 status port0");
        rd_expect(1, 1, 32'h2, "R1 status port1");
        rd_expect(0, 0, 32'h0, "R1 control port0");

        // R3 control mask, R11 flag out, R8 tx irq
        cpu_write(0, 0, 32'hFFFF_FFFF);
        rd_expect(0, 0, 32'h0000_7E1F, "R3 control readback");
        check("R11 flag out", 32'(host_flag_out[1:0]), 32'h3);
        check("R8 irq_tx on empty", 32'(irq_tx[0]), 32'h1);
        cpu_write(0, 1, 32'hFFFF_FFFF);
        rd_expect(0, 1, 32'h2, "R3 reserved write ignored");
        rd_expect(0, 0, 32'h0000_7E1F, "R3 control untouched");
        rd_expect(0, 2, 32'h0, "R2 reserved read zero");

        // R10 pending set
        pulse_req(0, 6'h3F);
        rd_expect(0, 1, 32'h0000_7E02, "R10 pending set");
        check("R10 irq_mem", 32'(irq_mem[0]), 32'h1);
        check("R10 mreq", 32'(host_mreq[0]), 32'h1);

        // R4 plain transmit then R6 transfer
        cpu_write(0, 3, 32'hA5A5_0001);
        #1;
        check("R4 status after plain write", cpu_rdata, 32'h0000_7E00);
        check("R4 irq_tx low", 32'(irq_tx[0]), 32'h0);
        @(negedge clk); #1;
        check("R6 data delivered", host_rdata[31:0], 32'hA5A5_0001);
        check("R6 rxfull set", 32'(host_rxfull[0]), 32'h1);
        check("R6 mreq cleared", 32'(host_mreq[0]), 32'h0);
        check("R6 empty set", cpu_rdata, 32'h0000_7E02);

        // R7 stall and release
        cpu_write(0, 3, 32'h0000_BEEF);
        repeat (3) @(negedge clk);
        #1;
        check("R7 held while full", host_rdata[31:0], 32'hA5A5_0001);
        check("R7 not empty while stalled", cpu_rdata, 32'h0000_7E00);
        pulse_hrd(0);
        #1;
        check("R7 rxfull cleared", 32'(host_rxfull[0]), 32'h0);
        @(negedge clk); #1;
        check("R7 stalled word moved", host_rdata[31:0], 32'h0000_BEEF);
        check("R7 rxfull again", 32'(host_rxfull[0]), 32'h1);

        // R5 clearing transmit write
        cpu_write(0, 2, 32'h1234_5678);
        #1;
        check("R5 read pending cleared", cpu_rdata, 32'h0000_5400);

        // R12 other port unaffected
        cpu_write(1, 3, 32'h0000_1111);
        @(negedge clk); #1;
        check("R12 port1 delivered", host_rdata[63:32], 32'h0000_1111);
        check("R12 port0 untouched", host_rdata[31:0], 32'h0000_BEEF);

        // R9 receive path, R8 rx irq
        cpu_write(1, 0, 32'h0000_0001);
        pulse_req(1, 6'h3F);
        @(negedge clk);
        host_wr[1] = 1'b1; host_wdata[63:32] = 32'h0000_CAFE;
        @(negedge clk);
        host_wr[1] = 1'b0;
        rd_expect(1, 1, 32'h0000_7E03, "R9 receive full");
        check("R8 irq_rx", 32'(irq_rx[1]), 32'h1);
        rd_expect(1, 3, 32'h0000_CAFE, "R9 receive data");
        cpu_read(1, 3);
        rd_expect(1, 1, 32'h0000_2A02, "R9 read clears full and write pending");
        check("R8 irq_rx low", 32'(irq_rx[1]), 32'h0);

        // R11 host flags and command
        @(negedge clk);
        host_flag_in[1:0] = 2'b11; host_cmd[0] = 1'b1;
        rd_expect(0, 1, 32'h0000_541C, "R11 flags in status");
        check("R8 irq_cmd", 32'(irq_cmd[0]), 32'h1);

        pulse_hrd(0);
        repeat (6) @(negedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule